// File: doc/BRIEF.md
# Mixerless digital QPSK phase modulator

This block turns a serial bit stream into a square-wave QPSK carrier using only counters, shift stages and a selector, with no multipliers. A free-running binary counter on the master clock supplies three rates: a half-rate enable, an eighth-rate square wave that serves as the carrier, and a sixteenth-rate bit tick. A short delay line, stepped by the half-rate enable, holds copies of the carrier, each a quarter period later than the one before. The undelayed carrier is the 0-degree phase. With the delayed copies it forms four phases at 90-degree spacing.

Serial bits are sampled once per bit tick and paired. Each completed pair is loaded into a two-bit holding register in one step, and that value picks one of the four phase copies through a Gray-ordered 4-to-1 selector. The result is a QPSK constellation rotated by 135 degrees from the usual 45/135/225/315-degree set, so the in-phase and quadrature parts take values in {-1, 0, 1}. Band-pass shaping and amplification are left to circuitry outside the block.

The stream has no back-pressure. The block sets the pace, and `bit_strobe` acts as a one-cycle ready. The source must hold the next bit on `ser_in` in the cycle where `bit_strobe` is high. Because no bit is ever refused, there is no valid input. Everything runs on one clock, and the counter taps act as clock enables.

Top module: `qpsk_mixerless_mod`

## Requirements
- R1: With the held pair at 00, `qpsk_out` is the carrier. It is a square wave of period 8 clocks that is low for 4 cycles and then high for 4 cycles, starting low in the first cycle after reset is released.
- R2: `bit_strobe` is high for exactly one cycle in every 16. It is high in cycles 15, 31, 47, … counted from 0 at the first cycle after reset release.
- R3: The held pair selects the phase in Gray order. Pair 01 gives the carrier delayed by 2 clocks (90 degrees), pair 11 gives a 4-clock delay (180 degrees) and pair 10 gives a 6-clock delay (270 degrees). Delayed copies read low until the carrier has propagated to them after reset.
- R4: `ser_in` is sampled at the end of each strobe cycle. Of two successive samples, the earlier one becomes `dibit[1]` and the later one becomes `dibit[0]`.
- R5: `dibit` changes only in the cycle after every second strobe, with both bits loaded together. It then holds for 32 cycles. Pairing starts with the first strobe after reset.
- R6: Synchronous active-high reset returns the block to its start state. After one clocked reset cycle, `dibit` is 00, `bit_strobe` is 0 and `qpsk_out` is 0, and a pair that was half collected is discarded.
- R7: The value of `ser_in` in cycles where `bit_strobe` is low has no effect on `dibit` or `qpsk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (fm) |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit, sampled when `bit_strobe` is high |
| bit_strobe | output | 1 | One-cycle pulse per bit slot (fm/16); acts as ready for `ser_in` |
| dibit | output | 2 | Currently held bit pair; bit 1 is the earlier bit |
| qpsk_out | output | 1 | Phase-modulated square wave at fm/8 |

## Verification
`bit_strobe` and the phase output are combinational reads of registered state. Both are due in the same cycle that the counter reaches the relevant value. A bit presented in a strobe cycle completes a pair at the end of that cycle, so the new `dibit` and the new output phase appear in the following cycle. The bench counts cycles from reset release and predicts every output for every cycle with closed-form arithmetic. Inputs are driven and outputs compared on the falling edge, half a period clear of the edge that updates the registers. The bench drives the complement of the intended bit outside strobe cycles. Any sampling in the wrong cycle therefore shows up as a wrong pair.

// File: rtl/qpskm_pkg.sv
package qpskm_pkg;
  localparam int unsigned NUM_PHASES = 4;
  typedef logic [1:0] pair_t;
  typedef logic [$clog2(NUM_PHASES)-1:0] tap_idx_t;

  // Gray order: 00->0, 01->1, 11->2, 10->3 quarter-period steps
  function automatic tap_idx_t pair_to_tap(input pair_t p);
    return tap_idx_t'({p[1], p[1] ^ p[0]});
  endfunction
endpackage

// File: rtl/qpskm_divider.sv
module qpskm_divider #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned CARRIER_BIT = 2
) (
  input  logic clk,
  input  logic rst,
  output logic half_en,
  output logic carrier,
  output logic bit_tick
);
  localparam int unsigned HALF_BIT = CARRIER_BIT - 2;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  assign half_en  = &count_q[HALF_BIT:0];
  assign carrier  = count_q[CARRIER_BIT];
  assign bit_tick = &count_q;

  // R1
  carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(carrier) |-> $past(half_en));

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/qpskm_phase_line.sv
module qpskm_phase_line #(
  parameter int unsigned TAPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            carrier,
  output logic [TAPS-1:0] taps
);
  localparam int unsigned STAGES = TAPS - 1;

  logic [STAGES-1:0] stage_q;

  assign taps[0] = carrier;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)       stage_q[g] <= 1'b0;
      else if (step) stage_q[g] <= taps[g];
    end
    assign taps[g+1] = stage_q[g];
  end

  // R3
  first_lag_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> taps[1] == $past(taps[0]));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(taps[TAPS-1]));
endmodule

// File: rtl/qpskm_pair_latch.sv
module qpskm_pair_latch
  import qpskm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  bit_in,
  output pair_t pair
);
  logic  early_q;
  logic  half_q;
  pair_t pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      half_q  <= 1'b0;
      pair_q  <= '0;
    end else if (tick) begin
      early_q <= bit_in;
      half_q  <= ~half_q;
      if (half_q) pair_q <= {early_q, bit_in};
    end
  end

  assign pair = pair_q;

  // R5
  pair_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pair_q) |-> ($past(tick) && $past(half_q)));

  // R5
  half_flip_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> half_q != $past(half_q));
endmodule

// File: rtl/qpsk_mixerless_mod.sv
module qpsk_mixerless_mod
  import qpskm_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned CARRIER_BIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_in,
  output logic       bit_strobe,
  output logic [1:0] dibit,
  output logic       qpsk_out
);
  logic                  half_en;
  logic                  carrier;
  logic                  tick;
  logic [NUM_PHASES-1:0] phase_taps;
  pair_t                 held;

  qpskm_divider #(.CNT_W(CNT_W), .CARRIER_BIT(CARRIER_BIT)) u_div (
    .clk      (clk),
    .rst      (rst),
    .half_en  (half_en),
    .carrier  (carrier),
    .bit_tick (tick)
  );

  qpskm_phase_line #(.TAPS(NUM_PHASES)) u_line (
    .clk     (clk),
    .rst     (rst),
    .step    (half_en),
    .carrier (carrier),
    .taps    (phase_taps)
  );

  qpskm_pair_latch u_pair (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .bit_in (ser_in),
    .pair   (held)
  );

  assign bit_strobe = tick;
  assign dibit      = held;
  assign qpsk_out   = phase_taps[pair_to_tap(held)];

  // R6
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (dibit == 2'b00 && !bit_strobe && !qpsk_out));
endmodule

// File: tb/qpsk_mixerless_mod_test.sv
`timescale 1ns/1ps
module qpsk_mixerless_mod_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       bit_strobe;
  logic [1:0] dibit;
  logic       qpsk_out;

  int checks = 0;
  int errors = 0;
  bit bits [64];

  always #4 clk = ~clk;

  qpsk_mixerless_mod uut (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .bit_strobe (bit_strobe),
    .dibit      (dibit),
    .qpsk_out   (qpsk_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int carrier_at(input int t);
    if (t < 0) return 0;
    return (t >> 2) & 1;
  endfunction

  function automatic int quarter_steps(input int pr);
    case (pr)
      0: return 0;
      1: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
    // R6 reset state after clocked reset cycles
    chk("R6 dibit", dibit, 0);
    chk("R6 strobe", bit_strobe, 0);
    chk("R6 out", qpsk_out, 0);
  endtask

  // Releases reset and runs ncycles; bit slot j carries bits[(j+off)%64]
  task automatic run_stream(input int ncycles, input int off);
    for (int s = 0; s < ncycles; s++) begin
      int slot = s / 16;
      bit b = bits[(slot + off) % 64];
      bit strobe_exp = (s % 16 == 15);
      int p = s / 32;
      int pr = 0;
      int d;
      rst = 1'b0;
      // R7: complement on non-strobe cycles must be ignored
      ser_in = strobe_exp ? b : ~b;
      #1;
      if (p > 0) pr = 2 * bits[(2 * (p - 1) + off) % 64] + bits[(2 * (p - 1) + 1 + off) % 64];
      d = quarter_steps(pr);
      chk("R2 strobe", bit_strobe, strobe_exp);
      chk("R4 R5 R7 dibit", dibit, pr);
      if (d == 0) chk("R1 carrier", qpsk_out, carrier_at(s));
      else        chk("R3 phase", qpsk_out, carrier_at(s - 2 * d));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // every ordered pair of dibits appears in the stream
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 4; c++) begin
        int k = (a * 4 + c) * 4;
        bits[k]     = a[1];
        bits[k + 1] = a[0];
        bits[k + 2] = c[1];
        bits[k + 3] = c[0];
      end
    do_reset(3);
    run_stream(32 * 33, 0);
    // R6: reset while only the first bit of a pair is held
    do_reset(2);
    run_stream(20, 7);
    do_reset(1);
    run_stream(300, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule